// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Port with Single and Continuous Transfer

This block drives a three-wire synchronous serial link as the clock master. Software loads a byte through a small register port. The block moves the byte from a one-deep transmit buffer into a shift register and clocks it out most-significant bit first on the serial data output. At the same time it can capture eight bits from the serial data input into a receive register. The serial clock is the system clock divided by a fixed even parameter. Two control bits pick the idle level of the clock and whether the first bit is presented before the first clock edge or on it, which gives four communication types.

Two transfer modes change how the block talks to its host. In single mode each frame is a separate transaction. Writes to the transmit buffer made while the port is busy are discarded, and the only interrupt is a completion pulse at the end of every frame. In continuous mode a transmit-empty pulse fires as soon as the buffer has been copied into the shift register, so the host can queue the next byte early. If that byte arrives before the current frame ends, the next frame follows with the serial clock keeping its exact period.

Top module: `sio_master`

## Requirements
- R1: Each frame carries the 8 bits written at address 1, sent most-significant bit first. After the frame, the serial data output keeps the level of the final bit (bit 0).
- R2: In continuous mode (control bit 0 = 1), a transmit-empty pulse is raised in the cycle after the transmit buffer is copied into the shift register. This happens once per frame.
- R3: In single mode (control bit 0 = 0), the transmit-empty pulse never fires. Exactly one completion pulse fires per frame, whether reception is enabled or not.
- R4: With reception enabled (control bit 1 = 1), the 8 captured bits are placed in the receive register (read at address 2) at frame end, first captured bit in bit 7, and a completion pulse fires. In continuous mode with reception disabled, no completion pulse fires and the receive register keeps its value.
- R5: In single mode, a write to address 1 while busy is discarded. It does not change the buffer read back at address 1 and does not alter the frame in progress.
- R6: Control bit 2 is clock polarity and bit 3 is data phase. The idle clock level is the inverse of the polarity bit. With phase 0, output data changes on the leading clock edge and input is sampled on the trailing edge. With phase 1, the first bit appears before the first edge, input is sampled on the leading edge and output changes on the trailing edge.
- R7: Busy (status bit 0 at address 3, and the busy port) rises the cycle after an accepted write and stays high through the frame. For a single frame it is high for 8·DIV+1 cycles.
- R8: In continuous mode, a byte written before the current frame ends starts the next frame with no gap, and busy stays high between the two frames. Without such a byte, the clock returns to idle and busy clears.
- R9: Both interrupt outputs are pulses one system clock wide.
- R10: Consecutive sampling edges of the serial clock are exactly DIV system clocks apart, including across chained frames.
- R11: The control register at address 0 reads back its low 4 bits. Writes to it while busy are ignored. Status at address 3 shows busy in bit 0 and a pending transmit byte in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 transmit |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 transmit, 2 receive, 3 status |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer pending or in progress |
| irq_tx | output | 1 | Transmit-buffer-empty pulse |
| irq_rx | output | 1 | Receive/transfer-complete pulse |

## Verification
In continuous mode with reception enabled, the end of one frame and the start of the next fall on the same clock edge. On that edge the received byte is taken from the shift register while the queued byte is loaded into it, and both interrupt pulses are issued together. The bench provokes this by refilling the transmit buffer right after each transmit-empty pulse, with a slave model feeding a different byte per frame. It then judges the outcome from three things: the order of the captured output bytes, the receive register holding the last frame's slave byte, and a sampling-edge spacing that never deviates from DIV across the boundary.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int FRAME_BITS = 8;

    // Control register layout, LSB first: mode, receive enable, polarity, phase
    typedef struct packed {
        logic dphase;
        logic cpol;
        logic rx_en;
        logic cont;
    } sio_cfg_t;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_TX   = 2'd1,
        ADR_RX   = 2'd2,
        ADR_STAT = 2'd3
    } sio_addr_e;

    // Idle level of the serial clock for a given polarity bit
    function automatic logic idle_level(input logic pol);
        return ~pol;
    endfunction

endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            localparam logic [CW-1:0] LAST = CW'(HALF - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            cpol,
    input  logic            dphase,
    input  logic            tick,
    input  logic            sdi,
    output logic            sck,
    output logic            sdo,
    output logic            active,
    output logic            done_now,
    output logic [BITS-1:0] rx_next
);
    localparam int EDGES = 2 * BITS;
    localparam int EW = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    logic [BITS-1:0] sh;
    logic [EW-1:0]   ecnt;
    logic            samp;
    logic            sck_n;    // clock normalised to idle-high
    logic            leading;

    assign leading  = ~ecnt[0];
    assign done_now = active && tick && (ecnt == LAST_EDGE);
    assign rx_next  = {sh[BITS-2:0], dphase ? samp : sdi};
    assign sck      = sck_n ^ cpol;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            ecnt   <= '0;
            samp   <= 1'b0;
            sck_n  <= 1'b1;
            sdo    <= 1'b0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= load_data;
            ecnt   <= '0;
            active <= 1'b1;
            sck_n  <= 1'b1;
            if (dphase) begin
                sdo <= load_data[BITS-1];
            end
        end else if (active && tick) begin
            sck_n <= ~sck_n;
            ecnt  <= ecnt + 1'b1;
            if (leading) begin
                if (dphase) begin
                    samp <= sdi;
                end else begin
                    sdo <= sh[BITS-1];
                end
            end else begin
                sh <= rx_next;
                if (dphase && (ecnt != LAST_EDGE)) begin
                    sdo <= sh[BITS-2];
                end
            end
            if (ecnt == LAST_EDGE) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_master.sv
module sio_master
    import sio_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sck,
    output logic       sdo,
    input  logic       sdi,
    output logic       busy,
    output logic       irq_tx,
    output logic       irq_rx
);
    localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
    localparam int CFGW = $bits(sio_cfg_t);

    sio_cfg_t              cfg_q;
    logic [FRAME_BITS-1:0] txbuf_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic [FRAME_BITS-1:0] rx_next;
    logic                  tx_full;
    logic                  active;
    logic                  done_now;
    logic                  tick;
    logic                  load;
    logic                  wr_tx;
    logic                  wr_ctl;
    logic                  accept_tx;
    logic                  irq_tx_q;
    logic                  irq_rx_q;
    logic                  mode_cont;
    logic                  mode_cpol;

    assign busy      = active | tx_full;
    assign wr_tx     = wr_en && (sio_addr_e'(wr_addr) == ADR_TX);
    assign wr_ctl    = wr_en && (sio_addr_e'(wr_addr) == ADR_CTRL);
    assign accept_tx = wr_tx && (cfg_q.cont || !busy);
    assign load      = tx_full && (!active || (done_now && cfg_q.cont));
    assign mode_cont = cfg_q.cont;
    assign mode_cpol = cfg_q.cpol;
    assign irq_tx    = irq_tx_q;
    assign irq_rx    = irq_rx_q;

    sio_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .tick (tick)
    );

    sio_engine #(.BITS(FRAME_BITS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (txbuf_q),
        .cpol      (cfg_q.cpol),
        .dphase    (cfg_q.dphase),
        .tick      (tick),
        .sdi       (sdi),
        .sck       (sck),
        .sdo       (sdo),
        .active    (active),
        .done_now  (done_now),
        .rx_next   (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            txbuf_q  <= '0;
            tx_full  <= 1'b0;
            rx_q     <= '0;
            irq_tx_q <= 1'b0;
            irq_rx_q <= 1'b0;
        end else begin
            if (wr_ctl && !busy) begin
                cfg_q <= sio_cfg_t'(wr_data[CFGW-1:0]);
            end
            if (load) begin
                tx_full <= 1'b0;
            end
            if (accept_tx) begin
                txbuf_q <= wr_data;
                tx_full <= 1'b1;
            end
            if (done_now && cfg_q.rx_en) begin
                rx_q <= rx_next;
            end
            irq_tx_q <= load && cfg_q.cont;
            irq_rx_q <= done_now && (!cfg_q.cont || cfg_q.rx_en);
        end
    end

    always_comb begin
        case (sio_addr_e'(rd_addr))
            ADR_CTRL: rd_data = {{(8-CFGW){1'b0}}, cfg_q};
            ADR_TX:   rd_data = txbuf_q;
            ADR_RX:   rd_data = rx_q;
            default:  rd_data = {6'b0, tx_full, busy};
        endcase
    end
endmodule

// File: rtl/sio_master_chk.sv
module sio_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       sck,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       cont,
    input logic       cpol,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] txbuf
);
    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq_tx |=> !irq_tx);

    assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq_rx |=> !irq_rx);

    assert_single_no_txirq_R3: assert property (@(posedge clk) disable iff (rst)
        !cont |-> !irq_tx);

    assert_idle_clock_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == !cpol));

    assert_single_done_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !cont) |-> irq_rx);

    assert_drop_write_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !cont && wr_en && wr_addr == 2'd1) |=> $stable(txbuf));

    assert_chain_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cont && irq_tx) |-> busy);
endmodule

bind sio_master sio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .sck     (sck),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .cont    (mode_cont),
    .cpol    (mode_cpol),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .txbuf   (txbuf_q)
);

// File: tb/tb_sio_master.sv
`timescale 1ns/1ps
module tb_sio_master;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sck, sdo, sdi, busy, irq_tx, irq_rx;

    always #2.5 clk = ~clk;

    sio_master #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sck(sck), .sdo(sdo), .sdi(sdi), .busy(busy),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // monitor state
    int cyc = 0, last_cyc = 0, busy_cyc = 0;
    int ntx = 0, nrx = 0, nfall = 0, nframes = 0;
    int pulse_bad = 0, ivl_bad = 0;
    bit have_last = 0, prev_busy = 0, prev_sck = 1, prev_itx = 0, prev_irx = 0;
    bit cur_cpol = 0, cur_dph = 0, is_samp;
    logic [2:0] bitcnt = '0;
    logic [7:0] cap = '0;
    logic [7:0] capq [0:63];
    logic [7:0] slave_byte;

    function automatic logic [7:0] spat(input int f);
        return 8'h3C ^ 8'(f * 37);
    endfunction

    always_comb begin
        slave_byte = spat(nframes);
        sdi = slave_byte[~bitcnt];
    end

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_sck  = sck;
            prev_busy = 0;
        end else begin
            if (busy) busy_cyc++;
            if (irq_tx) ntx++;
            if (irq_rx) nrx++;
            if ((irq_tx && prev_itx) || (irq_rx && prev_irx)) pulse_bad++;
            if (prev_busy && !busy) nfall++;
            if ((busy || prev_busy) && sck != prev_sck) begin
                is_samp = cur_dph ? (sck == cur_cpol) : (sck != cur_cpol);
                if (is_samp) begin
                    if (have_last && (cyc - last_cyc) != DIV) ivl_bad++;
                    have_last = 1;
                    last_cyc = cyc;
                    cap = {cap[6:0], sdo};
                    if (bitcnt == 3'd7) begin
                        if (nframes < 64) capq[nframes] = cap;
                        nframes++;
                    end
                    bitcnt = bitcnt + 3'd1;
                end
            end
            if (!busy && !prev_busy) have_last = 0;
            prev_busy = busy;
        end
        prev_sck = sck;
        prev_itx = irq_tx;
        prev_irx = irq_rx;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 2000);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_txirq();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_tx && n < 2000);
    endtask

    logic [7:0] v, txb, rx_before, ctl;
    int f0, tx0, rx0, fall0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(2'd3, v); chk(v == 8'h00, "R7 reset status", v, 0);
        rd(2'd0, v); chk(v == 8'h00, "R11 reset control", v, 0);
        chk(sck == 1'b1, "R6 reset idle clock", sck, 1);
        chk(irq_tx == 0 && irq_rx == 0, "R9 reset irqs", {irq_tx, irq_rx}, 0);

        // single mode sweep over all four types, receive on and off
        for (int t = 0; t < 4; t++) begin
            for (int r = 0; r < 2; r++) begin
                cur_cpol = t[1];
                cur_dph  = t[0];
                ctl = {4'b0, cur_dph, cur_cpol, r[0], 1'b0};
                wr(2'd0, ctl);
                rd(2'd0, v); chk(v == ctl, "R11 control readback", v, ctl);
                chk(sck == !cur_cpol, "R6 idle level", sck, !cur_cpol);
                rd(2'd2, rx_before);
                txb = 8'(t * 8'h47 + r * 8'h1B + 8'h96);
                f0 = nframes; tx0 = ntx; rx0 = nrx; busy_cyc = 0;
                wr(2'd1, txb);
                wait_idle();
                chk(nframes == f0 + 1, "R1 one frame", nframes, f0 + 1);
                chk(capq[f0] == txb, "R1 MSB-first data", capq[f0], txb);
                chk(sdo == txb[0], "R1 output holds last bit", sdo, txb[0]);
                chk(ntx == tx0, "R3 no transmit pulse", ntx - tx0, 0);
                chk(nrx == rx0 + 1, "R3 completion pulse", nrx - rx0, 1);
                chk(busy_cyc == 4 * DIV * 2 + 1, "R7 busy length", busy_cyc, 8 * DIV + 1);
                chk(sck == !cur_cpol, "R6 clock back to idle", sck, !cur_cpol);
                rd(2'd2, v);
                if (r == 1) chk(v == spat(f0), "R4 received byte", v, spat(f0));
                else        chk(v == rx_before, "R4 receive reg kept", v, rx_before);
            end
        end

        // single mode: writes during a frame are dropped
        cur_cpol = 0; cur_dph = 0;
        wr(2'd0, 8'h02);
        f0 = nframes;
        wr(2'd1, 8'hC3);
        repeat (6) @(negedge clk);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h0F);
        rd(2'd3, v); chk(v[0] == 1'b1, "R11 status busy bit", v, 1);
        rd(2'd1, v); chk(v == 8'hC3, "R5 buffer untouched", v, 8'hC3);
        wait_idle();
        repeat (40) @(negedge clk);
        chk(nframes == f0 + 1, "R5 no extra frame", nframes, f0 + 1);
        chk(capq[f0] == 8'hC3, "R5 frame undisturbed", capq[f0], 8'hC3);
        rd(2'd0, v); chk(v == 8'h02, "R11 control locked while busy", v, 2);

        // continuous with reception: three chained frames (type polarity 1, phase 0)
        cur_cpol = 1; cur_dph = 0;
        wr(2'd0, 8'h07);
        f0 = nframes; tx0 = ntx; rx0 = nrx; fall0 = nfall;
        wr(2'd1, 8'hA1);
        wait_txirq();
        wr(2'd1, 8'h6E);
        rd(2'd3, v); chk(v == 8'h03, "R11 status pending", v, 3);
        wait_txirq();
        wr(2'd1, 8'h1F);
        wait_idle();
        chk(nframes == f0 + 3, "R8 three frames", nframes, f0 + 3);
        chk(capq[f0] == 8'hA1 && capq[f0+1] == 8'h6E && capq[f0+2] == 8'h1F,
            "R8 frame order", {capq[f0], capq[f0+1], capq[f0+2]}, 24'hA16E1F);
        chk(nfall == fall0 + 1, "R8 busy held between frames", nfall - fall0, 1);
        chk(ntx == tx0 + 3, "R2 transmit pulses", ntx - tx0, 3);
        chk(nrx == rx0 + 3, "R4 completion pulses", nrx - rx0, 3);
        rd(2'd2, v); chk(v == spat(f0 + 2), "R4 last received byte", v, spat(f0 + 2));

        // continuous transmit-only (polarity 1, phase 1)
        cur_cpol = 1; cur_dph = 1;
        wr(2'd0, 8'h0D);
        rd(2'd2, rx_before);
        f0 = nframes; tx0 = ntx; rx0 = nrx;
        wr(2'd1, 8'h3B);
        wait_txirq();
        wr(2'd1, 8'hD4);
        wait_idle();
        chk(capq[f0] == 8'h3B && capq[f0+1] == 8'hD4, "R8 tx-only chain",
            {capq[f0], capq[f0+1]}, 16'h3BD4);
        chk(nrx == rx0, "R4 no completion tx-only", nrx - rx0, 0);
        chk(ntx == tx0 + 2, "R2 transmit pulses tx-only", ntx - tx0, 2);
        rd(2'd2, v); chk(v == rx_before, "R4 receive reg kept", v, rx_before);
        rd(2'd3, v); chk(v == 8'h00, "R8 busy cleared", v, 0);

        chk(pulse_bad == 0, "R9 single-cycle pulses", pulse_bad, 0);
        chk(ivl_bad == 0, "R10 sampling edge spacing", ivl_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule